// File: doc/BRIEF.md
# PLL Divider Re-initialisation Sequencer

This block runs from a free-running reference clock that never depends on the clocks a serial transceiver recovers or produces. It watches the transceiver's transmit and receive PLL lock-detect signals. When the selected lock condition has held long enough, it sends a fixed double pulse on a test control bit. That double pulse restarts the PLL output dividers, which can come up stuck or at the wrong rate after configuration or after a PLL reset.

After the second pulse, the block asks for a reset of the transmit path. This clears, or prevents, an overflow in the transmit phase-compensation FIFO. It then raises a completion flag. If the lock condition is lost at any point, the sequencer drops back to idle and starts the whole sequence again the next time lock is seen.

The lock-wait delay, the pulse width, the gap between pulses and the reset-request length are all parameters. Their defaults are 1024, 256, 256 and 16 cycles.

Top module: `pll_divreinit_seq`

## Requirements
- R1: Each lock-detect input passes through a two-stage synchronizer. A lock change that is first sampled on clock edge k acts on the sequencer at edge k+2.
- R2: Leaving idle starts the wait. The pulse output rises WAIT_CYC edges after the sequencer leaves idle, which is WAIT_CYC+2 edges after the edge that first samples a qualifying lock.
- R3: When rx_only_i is 0, the qualified lock is the AND of the transmit and receive lock inputs. Receive lock alone does not start the sequence.
- R4: Exactly two pulses appear on div_pulse_o for each run. Each pulse is high for PULSE_CYC consecutive cycles.
- R5: Between the two pulses, div_pulse_o is low for exactly GAP_CYC cycles.
- R6: tx_rst_req_o rises on the same edge that the second pulse falls, and stays high for RST_CYC cycles. At most one of the three outputs is high at any time.
- R7: done_o rises on the edge where tx_rst_req_o falls. It stays high until reset or until the qualified lock is lost.
- R8: If the qualified lock is lost in any non-idle phase, all outputs go low and the sequencer returns to idle. The next lock then restarts the full wait.
- R9: Reset is synchronous and active-low. While it is applied, all three outputs are low.
- R10: When rx_only_i is 1, the qualified lock is the receive lock alone. The transmit lock input has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_lock_i | input | 1 | Transmit PLL lock detect, asynchronous |
| rx_lock_i | input | 1 | Receive PLL lock detect, asynchronous |
| rx_only_i | input | 1 | 1: qualify on receive lock only; 0: on both locks. Static setting |
| div_pulse_o | output | 1 | Divider re-initialisation pulse to the test control bit |
| tx_rst_req_o | output | 1 | Transmit-path reset request |
| done_o | output | 1 | Sequence complete |

## Verification
A phase counter that slips by even one cycle moves a pulse edge, the gap or the reset request. The per-cycle reference comparison flags this on the first cycle where the edges disagree, usually within the first pulse of a run.

A wrong lock-qualification term or a wrong synchronizer depth shifts the start of every run. It shows up as a miscompare WAIT_CYC cycles after lock is applied.

A state that fails to return to idle on loss of lock leaves an output high. The bench sees that two edges after the drop. A completion flag that never latches shows at the end of the reset request.

// File: rtl/pll_divreinit_pkg.sv
// Shared types for the PLL divider re-initialisation sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pll_divreinit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PULSE_A,
        ST_GAP,
        ST_PULSE_B,
        ST_RSTREQ,
        ST_DONE
    } seq_state_e;

    // Largest of four positive counts, used to size the shared timer.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lock_sync.sv
// Two-stage synchronizer for a bundle of independent level signals.
// Assumes each bit changes slowly relative to clk and that the bits need
// not stay coherent with each other. Reset forces every stage low.
module lock_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Two flops per bit: first catches, second settles.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_i[b];
                    stab_q <= meta_q;
                end
            end

            assign sync_o[b] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/seq_timer.sv
// Phase timer: counts cycles since the last clear and saturates at all-ones.
// Assumes the owner clears it on every phase change.
module seq_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    output logic [CW-1:0] count_o
);

    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    // Clear-or-increment counter with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_o <= '0;
        end else if (count_o != TOP) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/pll_divreinit_seq.sv
// Lock-qualified double-pulse sequencer. After a qualified PLL lock it
// waits WAIT_CYC cycles and then drives two PULSE_CYC-wide pulses separated
// by GAP_CYC low cycles. It then requests a transmit reset for RST_CYC
// cycles and holds done. Any loss of qualified lock returns it to idle.
// Assumes clk is free-running and independent of the transceiver's clocks,
// that rx_only_i is static, and that every count parameter is at least 1.
module pll_divreinit_seq
    import pll_divreinit_pkg::*;
#(
    parameter int WAIT_CYC  = 1024,
    parameter int PULSE_CYC = 256,
    parameter int GAP_CYC   = 256,
    parameter int RST_CYC   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_lock_i,
    input  logic rx_lock_i,
    input  logic rx_only_i,
    output logic div_pulse_o,
    output logic tx_rst_req_o,
    output logic done_o
);

    localparam int MAXC = max4(WAIT_CYC, PULSE_CYC, GAP_CYC, RST_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LAST_WAIT  = CW'(WAIT_CYC - 1);
    localparam logic [CW-1:0] LAST_PULSE = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LAST_GAP   = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] LAST_RST   = CW'(RST_CYC - 1);

    logic [1:0]    lock_s;      // [1] transmit, [0] receive
    logic          lock_ok;
    logic [CW-1:0] cnt;
    logic          tmr_clr;
    seq_state_e    state_q, state_d;

    lock_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tx_lock_i, rx_lock_i}),
        .sync_o  (lock_s)
    );

    // Qualify lock: receive alone in rx-only mode, otherwise both PLLs.
    always_comb begin
        lock_ok = rx_only_i ? lock_s[0] : (lock_s[0] & lock_s[1]);
    end

    seq_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clr),
        .count_o (cnt)
    );

    // Next phase: advance when the phase timer reaches its last cycle.
    always_comb begin
        state_d = state_q;
        if (!lock_ok) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_WAIT;
                ST_WAIT:    if (cnt == LAST_WAIT)  state_d = ST_PULSE_A;
                ST_PULSE_A: if (cnt == LAST_PULSE) state_d = ST_GAP;
                ST_GAP:     if (cnt == LAST_GAP)   state_d = ST_PULSE_B;
                ST_PULSE_B: if (cnt == LAST_PULSE) state_d = ST_RSTREQ;
                ST_RSTREQ:  if (cnt == LAST_RST)   state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Restart the timer on every phase change and keep it parked when idle or done.
    always_comb begin
        tmr_clr = (state_d != state_q) || (state_q == ST_IDLE) || (state_q == ST_DONE);
    end

    // Phase register and registered outputs decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            div_pulse_o  <= 1'b0;
            tx_rst_req_o <= 1'b0;
            done_o       <= 1'b0;
        end else begin
            state_q      <= state_d;
            div_pulse_o  <= (state_d == ST_PULSE_A) || (state_d == ST_PULSE_B);
            tx_rst_req_o <= (state_d == ST_RSTREQ);
            done_o       <= (state_d == ST_DONE);
        end
    end

    // R6: at most one output active at a time.
    p_outputs_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({div_pulse_o, tx_rst_req_o, done_o}));

    // R6: the reset request begins only as a pulse ends.
    p_req_follows_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rst_req_o) |-> $past(div_pulse_o));

    // R7: done begins only as the reset request ends.
    p_done_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(tx_rst_req_o));

    // R7: done holds while the lock stays qualified.
    p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && lock_ok) |=> done_o);

    // R8: losing the lock clears every output on the next edge.
    p_drop_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_ok |=> (!div_pulse_o && !tx_rst_req_o && !done_o));

    // R9: reset forces every output low.
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (!div_pulse_o && !tx_rst_req_o && !done_o));

endmodule

// File: tb/pll_divreinit_seq_test.sv
`timescale 1ns/100ps
module pll_divreinit_seq_test;

    localparam int W = 20;
    localparam int P = 6;
    localparam int G = 5;
    localparam int R = 4;
    localparam int E = W + 2*P + G + R;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_lock = 1'b0;
    logic rx_lock = 1'b0;
    logic rx_only = 1'b0;
    logic div_pulse, tx_rst_req, done;

    int n_chk = 0;
    int n_bad = 0;
    int pulse_rises = 0;
    bit started = 0;
    bit finished = 0;

    // Reference model state
    logic [1:0] m1 = 2'b00, m2 = 2'b00;
    int run = -1;
    logic mq;
    logic prev_pulse = 1'b0;

    always #2.5 clk = ~clk;

    pll_divreinit_seq #(.WAIT_CYC(W), .PULSE_CYC(P), .GAP_CYC(G), .RST_CYC(R)) uut (
        .clk(clk), .rst_n(rst_n), .tx_lock_i(tx_lock), .rx_lock_i(rx_lock),
        .rx_only_i(rx_only), .div_pulse_o(div_pulse), .tx_rst_req_o(tx_rst_req),
        .done_o(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Behavioural model: run counts cycles since the sequence left idle.
    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 2'b00; m2 = 2'b00; run = -1;
        end else begin
            mq = rx_only ? m2[0] : (m2[0] & m2[1]);
            if (!mq) run = -1;
            else if (run < 0) run = 0;
            else if (run < E) run++;
            m2 = m1;
            m1 = {tx_lock, rx_lock};
        end
        started = 1;
    end

    function automatic logic [2:0] model_out(input int t);
        logic p, q, d;
        p = (t >= W && t < W+P) || (t >= W+P+G && t < W+2*P+G);
        q = (t >= W+2*P+G && t < E);
        d = (t >= E);
        return {p, q, d};
    endfunction

    function automatic string phase_tag(input int t);
        if (!rst_n)          return "R9";
        if (t < 0)           return (m1 != 2'b00 || m2 != 2'b00) ? "R1" : "R8";
        if (t < W)           return "R2";
        if (t < W+P)         return "R4";
        if (t < W+P+G)       return "R5";
        if (t < W+2*P+G)     return "R4";
        if (t < E)           return "R6";
        return "R7";
    endfunction

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk({div_pulse, tx_rst_req, done} === model_out(run), phase_tag(run),
                {div_pulse, tx_rst_req, done}, model_out(run));
            if (div_pulse && !prev_pulse) pulse_rises++;
            prev_pulse = div_pulse;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        cycles(3);
        chk({div_pulse, tx_rst_req, done} === 3'b000, "R9", {div_pulse, tx_rst_req, done}, 3'b000);
        rst_n = 1'b1;
        // R3: receive lock alone must not start in both-lock mode.
        rx_lock = 1'b1;
        cycles(40);
        chk(pulse_rises == 0, "R3", 3'(pulse_rises), 3'd0);
        // Full run with both locks.
        tx_lock = 1'b1;
        pulse_rises = 0;
        cycles(E + 15);
        chk(pulse_rises == 2, "R4", 3'(pulse_rises), 3'd2);
        chk(done === 1'b1, "R7", {2'b00, done}, 3'b001);
        // R8: drop while done, then drop during the gap, then a clean run.
        tx_lock = 1'b0;
        cycles(5);
        tx_lock = 1'b1;
        cycles(W + P + 3);
        rx_lock = 1'b0;
        cycles(4);
        rx_lock = 1'b1;
        pulse_rises = 0;
        cycles(E + 8);
        chk(pulse_rises == 2, "R8", 3'(pulse_rises), 3'd2);
        // R10: rx-only mode with transmit lock toggling.
        rx_lock = 1'b0;
        cycles(4);
        rx_only = 1'b1;
        tx_lock = 1'b0;
        rx_lock = 1'b1;
        pulse_rises = 0;
        for (int i = 0; i < E + 8; i++) begin
            tx_lock = i[2];
            @(negedge clk);
        end
        chk(pulse_rises == 2 && done === 1'b1, "R10", {div_pulse, tx_rst_req, done}, 3'b001);
        // R9: reset in the middle of a run.
        rx_lock = 1'b0;
        cycles(4);
        rx_lock = 1'b1;
        cycles(W + 4);
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(E + 8);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule